// File: doc/BRIEF.md
# Two-Channel Quadrature Pulse Counter

This block counts edges seen on two channels and keeps the result in one signed 16-bit counter. Each channel has a pulse line and a control line. Per-channel settings say what a rising or falling pulse edge does: hold, count up or count down. A second pair of settings says how the current control level changes that action. One channel on the pulse line and the other on the control line gives a quadrature decoder. Two plain edge sources give an up/down tally.

All four raw lines go through a two-flop synchronizer. They can then pass through an optional glitch filter. A level change only passes the filter once it has stayed put for a programmable number of clock cycles. Software can freeze the count, force it to zero, and program five watch points. These are a low limit, a high limit, two thresholds and zero. Each watch point sets a sticky status bit when it is enabled. The status bits merge into one interrupt line behind a single enable bit. Access is through a simple register port: a write strobe with an address and data, and a combinational read mux.

Top module: `pcnt_unit`

## Requirements
- R1: After reset every readable register returns 0: count, settings, limits, thresholds, control and status. `irq_o` is low.
- R2: Edge action codes in a 2-bit field are 0 = hold, 1 = add one, 2 = subtract one, and 3 = hold. In each channel's settings byte, the rising-edge action is in bits [1:0] and the falling-edge action is in bits [3:2]. Channel 0 uses byte 0 of the settings register and channel 1 uses byte 1.
- R3: Control modifier codes are 0 = keep the action, 1 = swap add and subtract, 2 = hold, and 3 = hold. Bits [5:4] of the channel byte apply while that channel's control line is high. Bits [7:6] apply while it is low.
- R4: Edges from both channels that land in the same cycle are summed, so +1 and -1 together leave the count unchanged and +1 with +1 adds two.
- R5: The count is a 16-bit two's-complement value. It reads at address 5 sign-extended to 32 bits and wraps modulo 2^16. Writes to address 5 are ignored.
- R6: While the pause bit (control register bit 0, address 3) is set, edges do not change the count. Once the bit is cleared, counting continues from the held value.
- R7: While the zero-force bit (control register bit 1) is set, the count is 0 and edges are ignored. Once it is released, counting restarts from 0.
- R8: The low limit sits at address 1 bits [15:0] and the high limit at address 1 bits [31:16]. When a count step would land on either limit, the count becomes 0 in that same cycle. The matching status bit is set if it is enabled: bit 0 for the low limit, bit 1 for the high limit.
- R9: Threshold A sits at address 2 bits [15:0] and threshold B at bits [31:16]. A count step that lands on A sets status bit 2, on B sets bit 3, and on 0 sets bit 4. The enable for status bit k is settings bit 27+k. A disabled watch point never sets its bit.
- R10: Status reads at address 4. Writing 1 to a bit at address 4 clears that bit, and bits written 0 are kept.
- R11: `irq_o` is high exactly when the interrupt-enable bit (control register bit 2) is set and at least one status bit is set.
- R12: Settings bit 16 turns on the glitch filter and bits [26:17] hold its threshold. With the filter on, a line level that lasts fewer cycles than the threshold never reaches the edge detector, and a level that lasts longer is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 2 | Raw pulse line per channel |
| ctrl_i | input | 2 | Raw control line per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Read data for rd_addr_i, combinational |
| irq_o | output | 1 | Shared watch-point interrupt |

## Verification
Directed sequences drive each edge action and modifier code on its own. A mismatch there points to one field decode, for example a rising edge taken for a falling one, or a swap taken for a hold. Simultaneous edges on both channels with opposite and with equal signs separate true summing from last-writer-wins. Long random toggle sequences over random settings bytes and both control levels catch wrong cross-channel interactions and sign handling through zero. Short and long pulses with the filter on tell a working stability window apart from one that passes glitches or blocks real edges.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  localparam int CNT_W  = 16;
  localparam int FLT_W  = 10;
  localparam int N_CH   = 2;
  localparam int N_EV   = 5;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam int EV_LO   = 0;
  localparam int EV_HI   = 1;
  localparam int EV_TA   = 2;
  localparam int EV_TB   = 3;
  localparam int EV_ZERO = 4;

  localparam int FLT_EN_B = 8 * N_CH;
  localparam int FLT_LSB  = FLT_EN_B + 1;
  localparam int EV_LSB   = FLT_LSB + FLT_W;

  localparam logic [1:0] ACT_HOLD = 2'd0;
  localparam logic [1:0] ACT_INC  = 2'd1;
  localparam logic [1:0] ACT_DEC  = 2'd2;
  localparam logic [1:0] MOD_KEEP = 2'd0;
  localparam logic [1:0] MOD_INV  = 2'd1;

  localparam logic [ADDR_W-1:0] A_CFG = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIM = 3'd1;
  localparam logic [ADDR_W-1:0] A_THR = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTL = 3'd3;
  localparam logic [ADDR_W-1:0] A_STS = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT = 3'd5;

  typedef struct packed {
    logic [1:0] lo_mod;
    logic [1:0] hi_mod;
    logic [1:0] fall_act;
    logic [1:0] rise_act;
  } chan_cfg_t;
endpackage

// File: rtl/pcnt_in_filter.sv
module pcnt_in_filter #(
  parameter int FLT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  input  logic             en_i,
  input  logic [FLT_W-1:0] thr_i,
  output logic             q_o
);
  logic             s1_q, s2_q;
  logic [FLT_W-1:0] run_q;
  logic             run_done;

  assign run_done = ({1'b0, run_q} + 1'b1) >= {1'b0, thr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      q_o   <= 1'b0;
      run_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      if (!en_i) begin
        q_o   <= s2_q;
        run_q <= '0;
      end else if (s2_q == q_o) begin
        run_q <= '0;
      end else if (run_done) begin
        q_o   <= s2_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assert_filter_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(s2_q != q_o && run_done)) |=> $stable(q_o));
endmodule

// File: rtl/pcnt_chan_step.sv
module pcnt_chan_step
  import pcnt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pulse_i,
  input  logic        ctrl_i,
  input  chan_cfg_t   cfg_i,
  output logic [1:0]  step_o
);
  logic       prev_q;
  logic       rise, fall;
  logic [1:0] act, mod;
  logic [1:0] base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pulse_i;
  end

  assign rise = pulse_i & ~prev_q;
  assign fall = ~pulse_i & prev_q;

  always_comb begin
    act = rise ? cfg_i.rise_act : (fall ? cfg_i.fall_act : ACT_HOLD);
    mod = ctrl_i ? cfg_i.hi_mod : cfg_i.lo_mod;
    unique case (act)
      ACT_INC: base = 2'b01;
      ACT_DEC: base = 2'b11;
      default: base = 2'b00;
    endcase
    unique case (mod)
      MOD_KEEP: step_o = base;
      MOD_INV:  step_o = 2'b00 - base;
      default:  step_o = 2'b00;
    endcase
  end

  // a step only ever follows a pulse edge
  assert_step_needs_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o != 2'b00) |-> (pulse_i != prev_q));
  assert_step_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o != 2'b10);
endmodule

// File: rtl/pcnt_watch.sv
module pcnt_watch
  import pcnt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] raw_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] ta_i,
  input  logic [CNT_W-1:0] tb_i,
  input  logic [N_EV-1:0]  en_i,
  input  logic [N_EV-1:0]  clr_i,
  output logic             lim_hit_o,
  output logic [N_EV-1:0]  sts_o
);
  logic [N_EV-1:0] hit, set;

  always_comb begin
    hit          = '0;
    hit[EV_LO]   = raw_i == lo_i;
    hit[EV_HI]   = raw_i == hi_i;
    hit[EV_TA]   = raw_i == ta_i;
    hit[EV_TB]   = raw_i == tb_i;
    hit[EV_ZERO] = raw_i == '0;
    set          = upd_i ? (hit & en_i) : '0;
  end

  assign lim_hit_o = hit[EV_LO] | hit[EV_HI];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= (sts_o & ~clr_i) | set;
  end

  assert_set_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o & ~$past(sts_o) & ~$past(en_i)) == '0);
  assert_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0 && !upd_i) |=> ((sts_o & $past(clr_i)) == '0));
endmodule

// File: rtl/pcnt_unit.sv
module pcnt_unit
  import pcnt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   pulse_i,
  input  logic [N_CH-1:0]   ctrl_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int NL    = 2 * N_CH;
  localparam int SUM_W = $clog2(N_CH) + 2;

  logic [DATA_W-1:0] cfg_q, lim_q, thr_q;
  logic [2:0]        ctl_q;
  logic              pause_q, clr_q, irq_en_q;
  logic [NL-1:0]     line_raw, line_f;
  logic [1:0]        step [N_CH];
  logic [SUM_W-1:0]  sum;
  logic [CNT_W-1:0]  cnt_q, raw;
  logic              upd, lim_hit;
  logic [N_EV-1:0]   sts, sts_clr;

  assign pause_q  = ctl_q[0];
  assign clr_q    = ctl_q[1];
  assign irq_en_q = ctl_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      lim_q <= '0;
      thr_q <= '0;
      ctl_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_CFG:   cfg_q <= wr_data_i;
        A_LIM:   lim_q <= wr_data_i;
        A_THR:   thr_q <= wr_data_i;
        A_CTL:   ctl_q <= wr_data_i[2:0];
        default: ;
      endcase
    end
  end

  assign sts_clr  = (wr_en_i && wr_addr_i == A_STS) ? wr_data_i[N_EV-1:0] : '0;
  assign line_raw = {ctrl_i, pulse_i};

  for (genvar l = 0; l < NL; l++) begin : g_line
    pcnt_in_filter #(.FLT_W(FLT_W)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[l]),
      .en_i  (cfg_q[FLT_EN_B]),
      .thr_i (cfg_q[FLT_LSB +: FLT_W]),
      .q_o   (line_f[l])
    );
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    pcnt_chan_step u_step (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pulse_i(line_f[c]),
      .ctrl_i (line_f[N_CH + c]),
      .cfg_i  (chan_cfg_t'(cfg_q[8*c +: 8])),
      .step_o (step[c])
    );
  end

  always_comb begin
    sum = '0;
    for (int c = 0; c < N_CH; c++) sum = sum + {{(SUM_W-2){step[c][1]}}, step[c]};
  end

  assign raw = cnt_q + {{(CNT_W-SUM_W){sum[SUM_W-1]}}, sum};
  assign upd = !clr_q && !pause_q && (sum != '0);

  pcnt_watch u_watch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd),
    .raw_i    (raw),
    .lo_i     (lim_q[CNT_W-1:0]),
    .hi_i     (lim_q[2*CNT_W-1:CNT_W]),
    .ta_i     (thr_q[CNT_W-1:0]),
    .tb_i     (thr_q[2*CNT_W-1:CNT_W]),
    .en_i     (cfg_q[EV_LSB +: N_EV]),
    .clr_i    (sts_clr),
    .lim_hit_o(lim_hit),
    .sts_o    (sts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (clr_q) cnt_q <= '0;
    else if (upd)   cnt_q <= lim_hit ? '0 : raw;
  end

  assign irq_o = irq_en_q && (sts != '0);

  always_comb begin
    unique case (rd_addr_i)
      A_CFG:   rd_data_o = cfg_q;
      A_LIM:   rd_data_o = lim_q;
      A_THR:   rd_data_o = thr_q;
      A_CTL:   rd_data_o = {{(DATA_W-3){1'b0}}, ctl_q};
      A_STS:   rd_data_o = {{(DATA_W-N_EV){1'b0}}, sts};
      A_CNT:   rd_data_o = {{(DATA_W-CNT_W){cnt_q[CNT_W-1]}}, cnt_q};
      default: rd_data_o = '0;
    endcase
  end

  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> (cnt_q == '0));
  assert_pause_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_q && !clr_q) |=> $stable(cnt_q));
  assert_limit_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && lim_hit) |=> (cnt_q == '0));
  assert_step_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == '0) || ((cnt_q - $past(cnt_q) + CNT_W'(2)) <= CNT_W'(4)));
endmodule

// File: tb/pcnt_unit_bench.sv
module pcnt_unit_bench;
  localparam logic [2:0] A_CFG = 3'd0, A_LIM = 3'd1, A_THR = 3'd2,
                         A_CTL = 3'd3, A_STS = 3'd4, A_CNT = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pul = '0, ctl = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int tests = 0, fails = 0;
  logic [15:0] ecnt;
  logic [31:0] ecfg;

  always #2 clk = ~clk;

  pcnt_unit u_pcnt_unit (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pul), .ctrl_i(ctl),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic [7:0] cb(logic [1:0] r, logic [1:0] f, logic [1:0] h, logic [1:0] l);
    return {l, h, f, r};
  endfunction

  function automatic int step_of(logic [7:0] c, bit rising, bit cl);
    int a;
    logic [1:0] act, md;
    act = rising ? c[1:0] : c[3:2];
    md  = cl ? c[5:4] : c[7:6];
    a = (act == 2'd1) ? 1 : ((act == 2'd2) ? -1 : 0);
    if (md == 2'd1) a = -a;
    else if (md != 2'd0) a = 0;
    return a;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic settle(int n = 8);
    repeat (n) @(negedge clk);
  endtask

  task automatic tog(int ch);
    @(negedge clk); pul[ch] = ~pul[ch]; settle();
  endtask

  task automatic tog_both();
    @(negedge clk); pul = ~pul; settle();
  endtask

  task automatic chk_cnt(string tag, int v);
    logic [31:0] d;
    rd(A_CNT, d);
    chk(tag, d, 32'(v));
  endtask

  task automatic chk_sts(string tag, logic [4:0] v);
    logic [31:0] d;
    rd(A_STS, d);
    chk(tag, d, {27'd0, v});
  endtask

  task automatic zero_cnt();
    wr(A_CTL, 32'd2); wr(A_CTL, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    rd(A_CNT, d); chk("R1 count", d, 0);
    rd(A_STS, d); chk("R1 status", d, 0);
    rd(A_CFG, d); chk("R1 cfg", d, 0);
    rd(A_CTL, d); chk("R1 ctl", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    wr(A_LIM, {16'h7fff, 16'h8000});

    // R2 edge actions
    wr(A_CFG, {16'd0, 8'd0, cb(2'd1, 2'd2, 2'd0, 2'd0)});
    tog(0); chk_cnt("R2 rise inc", 1);
    tog(0); chk_cnt("R2 fall dec", 0);
    tog(0); chk_cnt("R2 rise again", 1);

    // R3 control modifiers
    wr(A_CFG, {16'd0, 8'd0, cb(2'd1, 2'd2, 2'd2, 2'd1)});
    tog(0); chk_cnt("R3 low level inverts", 2);
    @(negedge clk); ctl[0] = 1'b1; settle();
    tog(0); chk_cnt("R3 high level holds", 2);
    @(negedge clk); ctl[0] = 1'b0; settle();
    tog(0); chk_cnt("R3 low level fall inverted", 3);

    // R7 zero force
    zero_cnt(); chk_cnt("R7 zero force", 0);

    // R4 simultaneous edges
    wr(A_CFG, {16'd0, cb(2'd2, 2'd2, 2'd0, 2'd0), cb(2'd1, 2'd1, 2'd0, 2'd0)});
    tog_both(); chk_cnt("R4 opposite cancel", 0);
    wr(A_CFG, {16'd0, cb(2'd1, 2'd1, 2'd0, 2'd0), cb(2'd1, 2'd1, 2'd0, 2'd0)});
    tog_both(); chk_cnt("R4 same add two", 2);

    // R5 negative readback
    zero_cnt();
    wr(A_CFG, {16'd0, 8'd0, cb(2'd2, 2'd2, 2'd0, 2'd0)});
    tog(0); tog(0); tog(0);
    chk_cnt("R5 sign extended", -3);
    wr(A_CNT, 32'h1234);
    chk_cnt("R5 write ignored", -3);

    // R6 pause
    wr(A_CTL, 32'd1);
    tog(0); tog(0);
    chk_cnt("R6 paused", -3);
    wr(A_CTL, 32'd0);
    tog(0); chk_cnt("R6 resumed", -4);

    // R7 edges ignored while forced
    wr(A_CTL, 32'd2);
    tog(0); chk_cnt("R7 held at zero", 0);
    wr(A_CTL, 32'd0);
    tog(0); chk_cnt("R7 restart from zero", -1);

    // R8 high limit
    zero_cnt();
    wr(A_LIM, {16'd4, 16'hfffe});
    wr(A_CFG, {5'b00010, 11'd0, 8'd0, cb(2'd1, 2'd1, 2'd0, 2'd0)});
    tog(0); tog(0); tog(0);
    chk_cnt("R8 below high", 3);
    chk_sts("R8 no event yet", 5'b00000);
    tog(0); chk_cnt("R8 high wraps to zero", 0);
    chk_sts("R8 high event", 5'b00010);

    // R11 interrupt gating
    chk("R11 irq gated off", {31'd0, irq}, 0);
    wr(A_CTL, 32'd4);
    chk("R11 irq on", {31'd0, irq}, 1);

    // R10 write one to clear
    wr(A_STS, 32'h2);
    chk_sts("R10 cleared", 5'b00000);
    chk("R11 irq drops", {31'd0, irq}, 0);

    // R8 low limit
    wr(A_CFG, {5'b00001, 11'd0, 8'd0, cb(2'd2, 2'd2, 2'd0, 2'd0)});
    tog(0); chk_cnt("R8 above low", -1);
    tog(0); chk_cnt("R8 low wraps to zero", 0);
    chk_sts("R8 low event", 5'b00001);
    wr(A_STS, 32'h1f);

    // R9 thresholds and zero
    wr(A_THR, {16'd3, 16'd2});
    wr(A_CFG, {5'b10100, 11'd0, 8'd0, cb(2'd1, 2'd1, 2'd0, 2'd0)});
    tog(0); tog(0);
    chk_sts("R9 threshold A", 5'b00100);
    tog(0); chk_cnt("R9 at B", 3);
    chk_sts("R9 B disabled", 5'b00100);
    wr(A_CFG, {5'b10100, 11'd0, 8'd0, cb(2'd2, 2'd2, 2'd0, 2'd0)});
    tog(0); tog(0); tog(0);
    chk_sts("R9 zero event", 5'b10100);
    chk("R11 irq with events", {31'd0, irq}, 1);
    wr(A_STS, 32'h4);
    chk_sts("R10 partial clear", 5'b10000);
    wr(A_STS, 32'h10);
    wr(A_CTL, 32'd0);

    // R12 glitch filter, threshold 10
    zero_cnt();
    wr(A_CFG, {5'd0, 10'd10, 1'b1, 8'd0, cb(2'd1, 2'd0, 2'd0, 2'd0)});
    @(negedge clk); pul[0] = 1'b1;
    settle(4);
    pul[0] = 1'b0;
    settle(30);
    chk_cnt("R12 short pulse ignored", 0);
    pul[0] = 1'b1;
    settle(20);
    pul[0] = 1'b0;
    settle(30);
    chk_cnt("R12 long pulse counted", 1);

    // random phase against bench model (R2 R3 R4 R5)
    wr(A_CFG, 32'd0);
    wr(A_LIM, {16'h7fff, 16'h8000});
    @(negedge clk); pul = '0; ctl = '0; settle();
    zero_cnt();
    ecnt = '0;
    ecfg = '0;
    for (int i = 0; i < 400; i++) begin
      int r, s;
      logic [15:0] raw;
      if (i % 40 == 0) begin
        ecfg = {16'd0, 16'($urandom())};
        wr(A_CFG, ecfg);
      end
      r = int'($urandom_range(0, 4));
      s = 0;
      @(negedge clk);
      case (r)
        0, 1: begin
          pul[r] = ~pul[r];
          s = step_of(ecfg[8*r +: 8], pul[r], ctl[r]);
        end
        2, 3: ctl[r-2] = ~ctl[r-2];
        default: begin
          pul = ~pul;
          for (int c = 0; c < 2; c++) s += step_of(ecfg[8*c +: 8], pul[c], ctl[c]);
        end
      endcase
      settle();
      if (s != 0) begin
        raw = ecnt + 16'(s);
        ecnt = (raw == 16'h7fff || raw == 16'h8000) ? 16'd0 : raw;
      end
      rd(A_CNT, d);
      chk("R4 random model count", d, {{16{ecnt[15]}}, ecnt});
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule